// File: doc/BRIEF.md
# Branch Flush and Trap Redirect Controller

This block is the piece of pipeline control that turns late control-flow events into fetch redirects and stage flushes. Fetch always proceeds on the sequential path, so a branch that is not taken costs nothing. Branches and jumps are resolved once they reach the memory stage; when one is taken, the three younger instructions sitting in fetch, decode and execute are on the wrong path and are squashed, which gives a fixed three-cycle penalty.

An arithmetic overflow raised in the execute stage is handled as a precise trap. Fetch is steered to a fixed handler address, the faulting instruction and the two behind it are squashed (so the faulting instruction never writes its register and no younger store reaches memory), and the address of the instruction after the faulting one is latched in a trap-return register. Since the memory stage holds an older instruction than execute, a taken branch seen in the same cycle as an overflow takes precedence and the overflow, which lies on the wrong path, is dropped.

The redirect and flush outputs are combinational in the cycle the event is seen, so the program counter and the pipeline registers act on them at the next clock edge. The block also merges the hazard unit's stall request into the decode bubble control and into the write enables of the program counter and the fetch/decode register.

Top module: `flush_redirect_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `trap_pc` reads zero; with no event and no stall, `pc_sel` is 2'b00 and all three flushes and `id_bubble` are low.
- R2: A branch in the memory stage whose condition is false (`mem_branch`=1, `mem_cond`=0, `mem_jump`=0) leaves `pc_sel` at 2'b00 (sequential) and raises no flush.
- R3: A taken control transfer (`mem_jump`=1, or `mem_branch`=1 with `mem_cond`=1) drives `pc_sel`=2'b01 and `pc_redirect`=`mem_target` and raises `if_flush`, `id_flush` and `ex_flush` together in that same cycle.
- R4: An overflow (`ex_ovf`=1) with no taken transfer drives `pc_sel`=2'b10, `pc_redirect`=32'h4000_0040 and raises all three flushes in that cycle, so the faulting instruction is squashed by `ex_flush` and the younger one by `id_flush`.
- R5: One cycle after an accepted overflow, `trap_pc` equals `ex_pc`+4 of that cycle, taken modulo 2^32; in any other cycle `trap_pc` holds its value.
- R6: When a taken transfer and an overflow occur in the same cycle, the branch wins: `pc_sel`=2'b01, `pc_redirect`=`mem_target`, and `trap_pc` is unchanged in the next cycle.
- R7: `id_bubble` is high whenever `id_flush` or `hz_stall` is high, and low otherwise.
- R8: A stall with no redirect lowers `pc_we` and `ifid_we`; any redirect keeps both high even while a stall is requested; with neither, both are high.
- R9: `pc_redirect` reads zero whenever `pc_sel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hz_stall | input | 1 | Stall request from the hazard detection unit |
| mem_branch | input | 1 | Conditional branch present in the memory stage |
| mem_jump | input | 1 | Unconditional jump present in the memory stage |
| mem_cond | input | 1 | Resolved branch condition in the memory stage |
| mem_target | input | 32 | Branch or jump target address |
| ex_ovf | input | 1 | Arithmetic overflow in the execute stage |
| ex_pc | input | 32 | Address of the instruction in execute |
| pc_sel | output | 2 | Next-PC source: 00 sequential, 01 branch target, 10 trap vector |
| pc_redirect | output | 32 | Redirect address when `pc_sel` is non-zero, else zero |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| if_flush | output | 1 | Zero the instruction field of the fetch/decode register |
| id_flush | output | 1 | Squash the instruction in decode |
| ex_flush | output | 1 | Zero the control lines of the execute pipeline register |
| id_bubble | output | 1 | Drive the decode control-zeroing mux |
| trap_pc | output | 32 | Saved return address after an overflow trap |

## Verification
The assertions watch, every cycle, that at most one redirect source is chosen, that a taken transfer always selects the target and flushes all three stages, that an accepted overflow selects the handler vector, that a stall without redirect freezes fetch, and that the trap-return register is loaded with the following address after a trap and stays put when a branch pre-empts the overflow. Only the bench scenarios show the exact addresses seen at the ports across mixed sequences: the wrap of the return address at the top of the address space, the not-taken branch with no penalty, and long random streams of stalls, branches and overflows compared against a behavioural model on every clock.

// File: rtl/redir_pkg.sv
package redir_pkg;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'b00,
    PCS_BRANCH = 2'b01,
    PCS_TRAP   = 2'b10
  } pc_src_e;

  // Address of the instruction after the one at 'pc', wrapping at 2^AW.
  function automatic logic [31:0] follow_addr(input logic [31:0] pc,
                                              input logic [31:0] step);
    follow_addr = pc + step;
  endfunction

  // A control transfer in the memory stage is taken when it is a jump
  // or a branch whose condition holds.
  function automatic logic is_taken(input logic jump,
                                    input logic branch,
                                    input logic cond);
    is_taken = jump | (branch & cond);
  endfunction

endpackage

// File: rtl/redir_arbiter.sv
module redir_arbiter
  import redir_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [31:0] TRAP_VEC  = 32'h4000_0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_branch,
  input  logic          mem_jump,
  input  logic          mem_cond,
  input  logic [AW-1:0] mem_target,
  input  logic          ex_ovf,
  output logic          br_taken,
  output logic          trap_acc,
  output pc_src_e       src,
  output logic [AW-1:0] redirect_addr
);

  // The memory stage holds the older instruction, so its event wins.
  always_comb begin
    br_taken = is_taken(mem_jump, mem_branch, mem_cond);
    trap_acc = ex_ovf & ~br_taken;
  end

  always_comb begin
    src           = PCS_SEQ;
    redirect_addr = '0;
    if (br_taken) begin
      src           = PCS_BRANCH;
      redirect_addr = mem_target;
    end else if (trap_acc) begin
      src           = PCS_TRAP;
      redirect_addr = TRAP_VEC[AW-1:0];
    end
  end

  // R6
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({br_taken, trap_acc}));

  // R4
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ovf && !mem_jump && !(mem_branch && mem_cond)) |->
      (src == PCS_TRAP && redirect_addr == TRAP_VEC[AW-1:0]));

  // R9
  seq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == PCS_SEQ) |-> (redirect_addr == '0));

endmodule

// File: rtl/redir_flush_gen.sv
module redir_flush_gen #(
  parameter int NSTAGE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect,
  input  logic              hz_stall,
  output logic [NSTAGE-1:0] flush_vec,
  output logic              id_bubble,
  output logic              pc_we,
  output logic              ifid_we
);

  // Every stage younger than the resolving point is squashed.
  for (genvar g = 0; g < NSTAGE; g++) begin : g_flush
    assign flush_vec[g] = redirect;
  end

  // Decode squash shares the control-zeroing mux with the stall bubble.
  always_comb begin
    id_bubble = flush_vec[1] | hz_stall;
    pc_we     = redirect | ~hz_stall;
    ifid_we   = redirect | ~hz_stall;
  end

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_stall && !redirect) |-> (!pc_we && !ifid_we && id_bubble));

  // R8
  redirect_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (pc_we && ifid_we));

endmodule

// File: rtl/redir_trap_reg.sv
module redir_trap_reg
  import redir_pkg::*;
#(
  parameter int          AW    = 32,
  parameter logic [31:0] ISTEP = 32'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_acc,
  input  logic          br_taken,
  input  logic          ex_ovf,
  input  logic [AW-1:0] ex_pc,
  output logic [AW-1:0] trap_pc
);

  logic [AW-1:0] ret_addr;

  always_comb ret_addr = follow_addr(ex_pc, ISTEP);

  always_ff @(posedge clk) begin
    if (!rst_n)        trap_pc <= '0;
    else if (trap_acc) trap_pc <= ret_addr;
  end

  // R5
  trap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_acc |=> (trap_pc == $past(ex_pc) + ISTEP[AW-1:0]));

  // R6
  branch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && ex_ovf) |=> $stable(trap_pc));

endmodule

// File: rtl/flush_redirect_ctrl.sv
module flush_redirect_ctrl
  import redir_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] TRAP_VEC = 32'h4000_0040,
  parameter logic [31:0] ISTEP    = 32'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hz_stall,
  input  logic          mem_branch,
  input  logic          mem_jump,
  input  logic          mem_cond,
  input  logic [AW-1:0] mem_target,
  input  logic          ex_ovf,
  input  logic [AW-1:0] ex_pc,
  output logic [1:0]    pc_sel,
  output logic [AW-1:0] pc_redirect,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          if_flush,
  output logic          id_flush,
  output logic          ex_flush,
  output logic          id_bubble,
  output logic [AW-1:0] trap_pc
);

  localparam int NSTAGE = 3;

  // Named internal events, visible to the assertions.
  logic              br_taken;
  logic              trap_acc;
  logic              redirect;
  pc_src_e           src;
  logic [NSTAGE-1:0] flush_vec;

  redir_arbiter #(.AW(AW), .TRAP_VEC(TRAP_VEC)) arb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_branch   (mem_branch),
    .mem_jump     (mem_jump),
    .mem_cond     (mem_cond),
    .mem_target   (mem_target),
    .ex_ovf       (ex_ovf),
    .br_taken     (br_taken),
    .trap_acc     (trap_acc),
    .src          (src),
    .redirect_addr(pc_redirect)
  );

  always_comb redirect = br_taken | trap_acc;

  redir_flush_gen #(.NSTAGE(NSTAGE)) flg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .redirect (redirect),
    .hz_stall (hz_stall),
    .flush_vec(flush_vec),
    .id_bubble(id_bubble),
    .pc_we    (pc_we),
    .ifid_we  (ifid_we)
  );

  redir_trap_reg #(.AW(AW), .ISTEP(ISTEP)) trp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trap_acc(trap_acc),
    .br_taken(br_taken),
    .ex_ovf  (ex_ovf),
    .ex_pc   (ex_pc),
    .trap_pc (trap_pc)
  );

  always_comb begin
    pc_sel   = src;
    if_flush = flush_vec[0];
    id_flush = flush_vec[1];
    ex_flush = flush_vec[2];
  end

  // R3
  taken_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_jump || (mem_branch && mem_cond)) |->
      (pc_sel == 2'b01 && pc_redirect == mem_target &&
       if_flush && id_flush && ex_flush));

  // R2
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_branch && !mem_cond && !mem_jump && !ex_ovf) |->
      (pc_sel == 2'b00 && !if_flush && !id_flush && !ex_flush));

endmodule

// File: tb/flush_redirect_ctrl_tb_top.sv
module flush_redirect_ctrl_tb_top;

  localparam logic [31:0] VEC = 32'h4000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hz_stall = 1'b0, mem_branch = 1'b0, mem_jump = 1'b0, mem_cond = 1'b0;
  logic [31:0] mem_target = '0;
  logic        ex_ovf = 1'b0;
  logic [31:0] ex_pc = '0;
  logic [1:0]  pc_sel;
  logic [31:0] pc_redirect, trap_pc;
  logic        pc_we, ifid_we, if_flush, id_flush, ex_flush, id_bubble;

  int n_chk = 0;
  int n_err = 0;
  longint exp_trap = 0;

  always #4 clk = ~clk;

  flush_redirect_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hz_stall(hz_stall),
    .mem_branch(mem_branch), .mem_jump(mem_jump), .mem_cond(mem_cond),
    .mem_target(mem_target), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .pc_sel(pc_sel), .pc_redirect(pc_redirect), .pc_we(pc_we),
    .ifid_we(ifid_we), .if_flush(if_flush), .id_flush(id_flush),
    .ex_flush(ex_flush), .id_bubble(id_bubble), .trap_pc(trap_pc)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: decide the cycle's outcome from the inputs,
  // compare all outputs, then record what the trap register must hold next.
  task automatic compare_cycle(input string req);
    bit taken, trap, redir;
    int  e_sel;
    longint e_addr;
    taken = mem_jump || (mem_branch && mem_cond);
    trap  = ex_ovf && !taken;
    redir = taken || trap;
    e_sel  = taken ? 1 : (trap ? 2 : 0);
    e_addr = taken ? longint'(mem_target) : (trap ? longint'(VEC) : 0);
    chk(req, "pc_sel", pc_sel, e_sel);
    chk(req, "pc_redirect", pc_redirect, e_addr);
    chk(req, "if_flush", if_flush, redir);
    chk(req, "id_flush", id_flush, redir);
    chk(req, "ex_flush", ex_flush, redir);
    chk("R7", "id_bubble", id_bubble, redir || hz_stall);
    chk("R8", "pc_we", pc_we, redir || !hz_stall);
    chk("R8", "ifid_we", ifid_we, redir || !hz_stall);
    chk("R5", "trap_pc", trap_pc, exp_trap);
    if (trap) exp_trap = (longint'(ex_pc) + 4) % (64'd1 << 32);
  endtask

  task automatic step(input bit st, input bit br, input bit jp, input bit cd,
                      input logic [31:0] tg, input bit ov, input logic [31:0] pc,
                      input string req);
    @(negedge clk);
    hz_stall = st; mem_branch = br; mem_jump = jp; mem_cond = cd;
    mem_target = tg; ex_ovf = ov; ex_pc = pc;
    #2;
    compare_cycle(req);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "trap_pc in reset", trap_pc, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 32'h0, 0, 32'h0, "R1");
    chk("R1", "idle pc_sel", pc_sel, 0);
    // R2: not-taken branch
    step(0, 1, 0, 0, 32'h0000_1234, 0, 32'h100, "R2");
    chk("R2", "no flush", if_flush | id_flush | ex_flush, 0);
    // R3: taken branch and jump
    step(0, 1, 0, 1, 32'h0000_0072, 0, 32'h44, "R3");
    chk("R3", "redirect to target", pc_redirect, 32'h72);
    step(1, 0, 1, 0, 32'h0000_0abc, 0, 32'h48, "R3");
    chk("R8", "redirect beats stall", pc_we, 1);
    step(0, 0, 0, 0, 32'h0, 0, 32'h0, "R9");
    chk("R9", "trap_pc untouched by branch", trap_pc, 0);
    // R4/R5: overflow trap
    step(0, 0, 0, 0, 32'h0, 1, 32'h0000_004c, "R4");
    chk("R4", "vector", pc_redirect, VEC);
    step(0, 0, 0, 0, 32'h0, 0, 32'h0, "R5");
    chk("R5", "saved return", trap_pc, 32'h50);
    // R6: collision, branch wins
    step(0, 1, 0, 1, 32'h0000_0200, 1, 32'h0000_0900, "R6");
    chk("R6", "branch selected", pc_sel, 1);
    step(0, 0, 0, 0, 32'h0, 0, 32'h0, "R6");
    chk("R6", "trap_pc kept", trap_pc, 32'h50);
    // R5: wrap at top of address space
    step(1, 0, 0, 0, 32'h0, 1, 32'hffff_fffc, "R5");
    step(0, 0, 0, 0, 32'h0, 0, 32'h0, "R5");
    chk("R5", "wrapped return", trap_pc, 0);
    // R7/R8: stall only
    step(1, 0, 0, 0, 32'h0, 0, 32'h0, "R8");
    chk("R7", "stall bubble", id_bubble, 1);
    // Random mixed stream
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 20) == 0,
           $urandom % 2, $urandom & 32'hffff_fffc, ($urandom % 10) == 0,
           $urandom & 32'hffff_fffc, "R3/R4");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule